// File: doc/BRIEF.md
# AES-128 Block Cipher Engine with Chaining

This block is an iterative AES-128 cipher. A host reaches it through a byte-wide register window. The window holds a 16-byte data block, a 16-byte key store and a control byte that selects direction and mode. A write of the start bit in either copy of the control byte launches one operation. The engine loads the block, runs one round per clock and writes the result back into the data block registers. It then raises a one-cycle completion pulse.

An encryption leaves the last round key in the key store in place of the cipher key. A decryption must begin from that key. It walks the key schedule backwards and leaves the original cipher key in the store. If the host has lost the decryption key, it can rebuild it in three steps:

1. Encrypt any block with the cipher key.
2. Read the key store.
3. Write that value back.

In chaining mode the engine XORs the new input block with the result of the previous encryption before it enciphers. A message checksum is built this way. The first block of a chain runs in plain mode, with the host's initialisation vector already folded in.

Top module: `aes_chain_engine`

## Requirements
- R1: A plain-mode encryption (control bits [5:4]=0, bit 2=0) of the standard AES-128 test vector produces the standard ciphertext in the data block registers.
- R2: After an encryption, the key store reads back the round-10 key of the key that was used.
- R3: A decryption (bit 2=1) started with the round-10 key restores the plaintext, and afterwards the key store holds the original cipher key.
- R4: Mode code 2 in bits [5:4] with bit 2=0 XORs the data block with the previous encryption result before encrypting. With bit 2=1 no such XOR is applied.
- R5: The chaining register takes the result of every encryption, whether plain or chained. Decryptions leave it unchanged. Reset clears it to zero.
- R6: Writing a control byte with bit 7=1 to 0x83 or 0x94 while idle starts an operation. Busy (read back as bit 7) is high for exactly 11 cycles. Done pulses for one cycle as busy falls.
- R7: While busy, writes to the data block, key store and control byte are ignored, and reads return the contents from before the start.
- R8: Data byte n (AES input order) is at 0x84+n and key byte n is at 0x70+n. Bits [6:0] of the control byte read back as written at both 0x83 and 0x94. Unmapped addresses read 0.
- R9: After reset all registers read 0 and busy is low.
- R10: The key-recovery sequence (dummy encryption, read the key store, write it back) gives a key that correctly decrypts the test ciphertext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for addr |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is stored |

## Verification
The bench builds the block with its default address map: control at 0x83, mirror at 0x94, data block at 0x84 and key store at 0x70. With this map it can reach every register byte and both unmapped gaps, and it can issue the start from either control copy. The bench checks the block against its own behavioural AES model over several chains. The chains cover a cold start after reset, a decryption placed between chained encryptions, and a decryption issued with the chaining code set.

// File: rtl/aes_eng_pkg.sv
package aes_eng_pkg;
  localparam int ROUNDS = 10;
  localparam int BLOCK_BYTES = 16;
  localparam int REQ_BIT = 7;
  localparam int DIR_BIT = 2;
  localparam int MODE_LSB = 4;
  localparam logic [1:0] MODE_CHAIN = 2'd2;

  typedef struct packed {
    logic       load;
    logic       step;
    logic       last;
    logic       decrypt;
    logic       chain;
    logic [3:0] rnd;
  } dpCtrl_t;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] s = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ s;
      s = xt(s);
    end
    return p;
  endfunction

  // multiplicative inverse as x^254
  function automatic logic [7:0] gInv(input logic [7:0] x);
    logic [7:0] r = 8'h01;
    logic [7:0] s = x;
    for (int i = 1; i < 8; i++) begin
      s = gmul(s, s);
      r = gmul(r, s);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] v = gInv(x);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [7:0] invSbox(input logic [7:0] x);
    logic [7:0] y = {x[6:0], x[7]} ^ {x[4:0], x[7:5]} ^ {x[1:0], x[7:2]} ^ 8'h05;
    return gInv(y);
  endfunction

  function automatic logic [127:0] subBytes(input logic [127:0] v, input logic inv);
    logic [127:0] o;
    for (int n = 0; n < BLOCK_BYTES; n++)
      o[8*n +: 8] = inv ? invSbox(v[8*n +: 8]) : sbox(v[8*n +: 8]);
    return o;
  endfunction

  function automatic logic [127:0] shiftRows(input logic [127:0] v, input logic inv);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        int src;
        src = inv ? 4 * ((c + 4 - r) % 4) + r : 4 * ((c + r) % 4) + r;
        o[8*(15-(4*c+r)) +: 8] = v[8*(15-src) +: 8];
      end
    return o;
  endfunction

  function automatic logic [127:0] mixCols(input logic [127:0] v, input logic inv);
    logic [127:0] o;
    logic [7:0] cf [4];
    cf = inv ? '{8'h0e, 8'h0b, 8'h0d, 8'h09} : '{8'h02, 8'h03, 8'h01, 8'h01};
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        logic [7:0] acc = 8'h00;
        for (int j = 0; j < 4; j++)
          acc = acc ^ gmul(cf[(j - r + 4) % 4], v[8*(15-(4*c+j)) +: 8]);
        o[8*(15-(4*c+r)) +: 8] = acc;
      end
    return o;
  endfunction

  function automatic logic [7:0] rcon(input logic [3:0] i);
    logic [7:0] r = 8'h01;
    for (int j = 1; j < ROUNDS; j++)
      if (j < int'(i)) r = xt(r);
    return r;
  endfunction

  function automatic logic [31:0] keyMix(input logic [31:0] w, input logic [7:0] rc);
    return {sbox(w[23:16]) ^ rc, sbox(w[15:8]), sbox(w[7:0]), sbox(w[31:24])};
  endfunction

  function automatic logic [127:0] keyFwd(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] n0, n1, n2, n3;
    n0 = k[127:96] ^ keyMix(k[31:0], rc);
    n1 = k[95:64] ^ n0;
    n2 = k[63:32] ^ n1;
    n3 = k[31:0] ^ n2;
    return {n0, n1, n2, n3};
  endfunction

  function automatic logic [127:0] keyBack(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] p0, p1, p2, p3;
    p3 = k[31:0] ^ k[63:32];
    p2 = k[63:32] ^ k[95:64];
    p1 = k[95:64] ^ k[127:96];
    p0 = k[127:96] ^ keyMix(p3, rc);
    return {p0, p1, p2, p3};
  endfunction
endpackage

// File: rtl/aes_eng_ctrl.sv
module aes_eng_ctrl
  import aes_eng_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h83,
  parameter logic [ADDR_W-1:0] MIRROR_ADDR = 8'h94
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output dpCtrl_t           cs,
  output logic              busy,
  output logic              done,
  output logic [7:0]        ctrlByte
);
  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_RUN} phase_t;

  phase_t     phaseQ;
  logic [3:0] rndQ;
  logic [6:0] cfgQ;
  logic       doneQ;
  logic       ctrlHit;
  logic       start;

  assign busy     = (phaseQ != PH_IDLE);
  assign ctrlHit  = wrEn && !busy && (addr == CTRL_ADDR || addr == MIRROR_ADDR);
  assign start    = ctrlHit && wrData[REQ_BIT];
  assign ctrlByte = {busy, cfgQ};
  assign done     = doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      rndQ   <= '0;
      cfgQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (ctrlHit) cfgQ <= wrData[6:0];
      unique case (phaseQ)
        PH_IDLE: if (start) phaseQ <= PH_LOAD;
        PH_LOAD: begin
          phaseQ <= PH_RUN;
          rndQ   <= 4'd1;
        end
        PH_RUN: begin
          rndQ <= rndQ + 4'd1;
          if (rndQ == 4'(ROUNDS)) begin
            phaseQ <= PH_IDLE;
            doneQ  <= 1'b1;
          end
        end
        default: phaseQ <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    cs.load    = (phaseQ == PH_LOAD);
    cs.step    = (phaseQ == PH_RUN);
    cs.last    = (rndQ == 4'(ROUNDS));
    cs.decrypt = cfgQ[DIR_BIT];
    cs.chain   = !cfgQ[DIR_BIT] && (cfgQ[MODE_LSB +: 2] == MODE_CHAIN);
    cs.rnd     = rndQ;
  end
endmodule

// File: rtl/aes_eng_dp.sv
module aes_eng_dp
  import aes_eng_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATE_BASE = 8'h84,
  parameter logic [ADDR_W-1:0] KEY_BASE = 8'h70
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           cs,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [127:0]      stateQ,
  output logic [127:0]      keyQ
);
  logic [127:0] chainQ, workQ, rkQ;
  logic [127:0] rkNext, fwdT, invT, roundOut, loadIn;

  always_comb begin
    rkNext   = cs.decrypt ? keyBack(rkQ, rcon(4'(ROUNDS + 1) - cs.rnd))
                          : keyFwd(rkQ, rcon(cs.rnd));
    fwdT     = shiftRows(subBytes(workQ, 1'b0), 1'b0);
    invT     = subBytes(shiftRows(workQ, 1'b1), 1'b1) ^ rkNext;
    if (cs.decrypt) roundOut = cs.last ? invT : mixCols(invT, 1'b1);
    else            roundOut = (cs.last ? fwdT : mixCols(fwdT, 1'b0)) ^ rkNext;
    loadIn   = (cs.chain ? (stateQ ^ chainQ) : stateQ) ^ keyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= '0;
      keyQ   <= '0;
      chainQ <= '0;
      workQ  <= '0;
      rkQ    <= '0;
    end else if (cs.load) begin
      workQ <= loadIn;
      rkQ   <= keyQ;
    end else if (cs.step) begin
      workQ <= roundOut;
      rkQ   <= rkNext;
      if (cs.last) begin
        stateQ <= roundOut;
        keyQ   <= rkNext;
        if (!cs.decrypt) chainQ <= roundOut;
      end
    end else if (hostWr) begin
      for (int n = 0; n < BLOCK_BYTES; n++) begin
        if (addr == ADDR_W'(int'(STATE_BASE) + n)) stateQ[8*(15-n) +: 8] <= wrData;
        if (addr == ADDR_W'(int'(KEY_BASE) + n))   keyQ[8*(15-n) +: 8]   <= wrData;
      end
    end
  end
endmodule

// File: rtl/aes_chain_engine.sv
module aes_chain_engine
  import aes_eng_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h83,
  parameter logic [ADDR_W-1:0] STATE_BASE = 8'h84,
  parameter logic [ADDR_W-1:0] MIRROR_ADDR = 8'h94,
  parameter logic [ADDR_W-1:0] KEY_BASE = 8'h70
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              busy,
  output logic              done
);
  dpCtrl_t      cs;
  logic [7:0]   ctrlByte;
  logic [127:0] stateQ, keyQ;

  aes_eng_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .MIRROR_ADDR(MIRROR_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .cs(cs), .busy(busy), .done(done), .ctrlByte(ctrlByte)
  );

  aes_eng_dp #(.ADDR_W(ADDR_W), .STATE_BASE(STATE_BASE), .KEY_BASE(KEY_BASE)) i_dp (
    .clk(clk), .rstN(rstN), .cs(cs), .hostWr(wrEn && !busy), .addr(addr), .wrData(wrData),
    .stateQ(stateQ), .keyQ(keyQ)
  );

  always_comb begin
    rdData = 8'h00;
    if (addr == CTRL_ADDR || addr == MIRROR_ADDR) rdData = ctrlByte;
    for (int n = 0; n < BLOCK_BYTES; n++) begin
      if (addr == ADDR_W'(int'(STATE_BASE) + n)) rdData = stateQ[8*(15-n) +: 8];
      if (addr == ADDR_W'(int'(KEY_BASE) + n))   rdData = keyQ[8*(15-n) +: 8];
    end
  end
endmodule

// File: rtl/aes_eng_chk.sv
module aes_eng_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h83,
  parameter logic [ADDR_W-1:0] MIRROR_ADDR = 8'h94
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wrData,
  input logic [7:0]        rdData,
  input logic              busy,
  input logic              done,
  input logic [127:0]      stateQ,
  input logic [127:0]      keyQ
);
  logic [4:0] busyCnt;
  logic       startReq;

  assign startReq = wrEn && !busy && (addr == CTRL_ADDR || addr == MIRROR_ADDR) && wrData[7];

  always_ff @(posedge clk) begin
    if (!rstN || !busy) busyCnt <= '0;
    else                busyCnt <= busyCnt + 5'd1;
  end

  AST_BUSY_ELEVEN: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> busyCnt == 5'd11); // R6
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN) startReq |=> busy); // R6
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy && $past(busy)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R6
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rstN) busy && $past(busy) |-> $stable(stateQ)); // R7
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rstN) busy && $past(busy) |-> $stable(keyQ)); // R7
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) && $stable(addr) |-> $stable(rdData)); // R7
endmodule

bind aes_chain_engine aes_eng_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .MIRROR_ADDR(MIRROR_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
  .busy(busy), .done(done), .stateQ(stateQ), .keyQ(keyQ)
);

// File: tb/test_aes_chain_engine.sv
module test_aes_chain_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h83;
  localparam logic [7:0] A_MIRR = 8'h94;
  localparam logic [7:0] A_STATE = 8'h84;
  localparam logic [7:0] A_KEY = 8'h70;
  localparam logic [127:0] FK  = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] FP  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] FC  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] FK10 = 128'h13111d7fe3944a17f307a78b4d2b30c5;

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [7:0] addr = 0, wrData = 0;
  logic [7:0] rdData;
  logic busy, done;
  int checks = 0, errors = 0;
  int mCnt = 0;
  bit mDone = 0;

  aes_chain_engine i_aes_chain_engine (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .busy(busy), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural timing model: 11 busy cycles, done on the cycle after
  always @(posedge clk) begin
    if (!rstN) begin mCnt = 0; mDone = 0; end
    else begin
      mDone = 0;
      if (mCnt > 0) begin mCnt--; if (mCnt == 0) mDone = 1; end
      else if (wrEn && (addr == A_CTRL || addr == A_MIRR) && wrData[7]) mCnt = 11;
    end
  end

  always @(negedge clk) if (rstN) begin
    checks++;
    if (busy !== (mCnt != 0) || done !== mDone) begin
      errors++;
      $display("FAIL R6 busy/done got %b/%b exp %b/%b", busy, done, mCnt != 0, mDone);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [7:0] bMul(input logic [7:0] a, input logic [7:0] b);
    int acc = 0;
    for (int i = 0; i < 8; i++) if (b[i]) acc = acc ^ (int'(a) << i);
    for (int i = 14; i >= 8; i--) if (acc[i]) acc = acc ^ (32'h11b << (i - 8));
    return acc[7:0];
  endfunction

  function automatic logic [7:0] bS(input logic [7:0] x);
    logic [7:0] inv = 0, o;
    for (int c = 1; c < 256; c++) if (bMul(x, 8'(c)) == 8'h01) inv = 8'(c);
    for (int i = 0; i < 8; i++)
      o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ (8'h63 >> i) & 1'b1;
    return o;
  endfunction

  task automatic refEnc(input logic [127:0] k, input logic [127:0] p,
                        output logic [127:0] c, output logic [127:0] lk);
    logic [31:0] w[44];
    logic [31:0] tmp;
    logic [7:0] s[16], t[16], rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      tmp = w[i-1];
      if (i % 4 == 0) begin
        tmp = {bS(tmp[23:16]) ^ rc, bS(tmp[15:8]), bS(tmp[7:0]), bS(tmp[31:24])};
        rc = bMul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ tmp;
    end
    for (int n = 0; n < 16; n++) s[n] = p[127-8*n -: 8] ^ w[n/4][31-8*(n%4) -: 8];
    for (int r = 1; r <= 10; r++) begin
      for (int n = 0; n < 16; n++) t[n] = bS(s[(n + 4*(n%4)) % 16]);
      for (int c4 = 0; c4 < 4; c4++) begin
        for (int j = 0; j < 4; j++) begin
          logic [7:0] a0, a1, a2, a3;
          a0 = t[4*c4 + j]; a1 = t[4*c4 + (j+1)%4]; a2 = t[4*c4 + (j+2)%4]; a3 = t[4*c4 + (j+3)%4];
          s[4*c4 + j] = (r < 10) ? (bMul(a0, 8'h02) ^ bMul(a1, 8'h03) ^ a2 ^ a3) : a0;
        end
      end
      for (int n = 0; n < 16; n++) s[n] = s[n] ^ w[4*r + n/4][31-8*(n%4) -: 8];
    end
    for (int n = 0; n < 16; n++) c[127-8*n -: 8] = s[n];
    lk = {w[40], w[41], w[42], w[43]};
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic wrBlock(input logic [7:0] base, input logic [127:0] v);
    for (int n = 0; n < 16; n++) wr(base + 8'(n), v[127-8*n -: 8]);
  endtask

  task automatic rdBlock(input logic [7:0] base, output logic [127:0] v);
    for (int n = 0; n < 16; n++) begin
      logic [7:0] b;
      rd(base + 8'(n), b);
      v[127-8*n -: 8] = b;
    end
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic runOp(input logic [127:0] key, input logic [127:0] blk, input logic [7:0] ctl,
                       output logic [127:0] res);
    wrBlock(A_KEY, key);
    wrBlock(A_STATE, blk);
    wr(A_MIRR, ctl);
    waitIdle();
    rdBlock(A_STATE, res);
  endtask

  initial begin
    logic [127:0] v, rk, c1, c2, ex, lk;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R9 reset state
    rdBlock(A_STATE, v); chk("R9 state after reset", v, '0);
    rdBlock(A_KEY, v);   chk("R9 key after reset", v, '0);
    rd(A_CTRL, b);       chk("R9 control after reset", 128'(b), 128'h0);

    // R1 / R2 / R7 encryption of the standard vector
    wrBlock(A_KEY, FK);
    wrBlock(A_STATE, FP);
    wr(A_MIRR, 8'h80);
    wr(A_STATE, 8'hAA);
    wr(A_KEY, 8'h55);
    wr(A_CTRL, 8'h24);
    rd(A_STATE, b); chk("R7 state read while busy", 128'(b), 128'h00);
    rd(A_KEY, b);   chk("R7 key read while busy", 128'(b), 128'h00);
    rd(A_MIRR, b);  chk("R6 busy bit reads 1", 128'(b), 128'h80);
    waitIdle();
    refEnc(FK, FP, ex, lk);
    rdBlock(A_STATE, v); chk("R1 ciphertext", v, FC);
    chk("R1 bench model ciphertext", v, ex);
    rdBlock(A_KEY, v);   chk("R2 last round key", v, FK10);
    chk("R2 bench model round key", v, lk);
    rd(A_CTRL, b); chk("R7 control write ignored", 128'(b), 128'h00);

    // R3 decryption from the last round key
    wr(A_CTRL, 8'h84);
    waitIdle();
    rdBlock(A_STATE, v); chk("R3 plaintext restored", v, FP);
    rdBlock(A_KEY, v);   chk("R3 key back to original", v, FK);

    // R10 key recovery sequence
    wrBlock(A_STATE, 128'hdeadbeef_01234567_89abcdef_55aa33cc);
    wr(A_CTRL, 8'h80);
    waitIdle();
    rdBlock(A_KEY, rk);
    chk("R10 recovered key", rk, FK10);
    wrBlock(A_STATE, FC);
    wrBlock(A_KEY, rk);
    wr(A_MIRR, 8'h84);
    waitIdle();
    rdBlock(A_STATE, v); chk("R10 decrypt with recovered key", v, FP);

    // R4 chaining
    runOp(FK, 128'h3243f6a8885a308d313198a2e0370734, 8'h80, c1);
    refEnc(FK, 128'h3243f6a8885a308d313198a2e0370734, ex, lk);
    chk("R4 first block plain", c1, ex);
    runOp(FK, 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0, 8'hA0, c2);
    refEnc(FK, 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0 ^ c1, ex, lk);
    chk("R4 chained block", c2, ex);
    // decryption with chaining code: no XOR, chain register untouched (R4, R5)
    wr(A_MIRR, 8'hA4);
    waitIdle();
    rdBlock(A_STATE, v);
    chk("R4 decrypt ignores chaining", v, 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0 ^ c1);
    runOp(FK, 128'h11111111222222223333333344444444, 8'hA0, v);
    refEnc(FK, 128'h11111111222222223333333344444444 ^ c2, ex, lk);
    chk("R5 chain kept across decryption", v, ex);

    // R5 plain encryption restarts the chain
    runOp(FK, 128'h00000000000000000000000000000001, 8'h80, c1);
    runOp(FK, 128'hffeeddccbbaa99887766554433221100, 8'hA0, v);
    refEnc(FK, 128'hffeeddccbbaa99887766554433221100 ^ c1, ex, lk);
    chk("R5 chain follows plain encryption", v, ex);

    // R8 register map
    wr(A_CTRL, 8'h35);
    rd(A_CTRL, b); chk("R8 control readback", 128'(b), 128'h35);
    rd(A_MIRR, b); chk("R8 mirror readback", 128'(b), 128'h35);
    rd(8'h00, b);  chk("R8 unmapped read low", 128'(b), 128'h00);
    rd(8'h95, b);  chk("R8 unmapped read high", 128'(b), 128'h00);
    rd(8'h80, b);  chk("R8 unmapped below window", 128'(b), 128'h00);

    // R5 reset clears the chain register
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    runOp(FK, FP, 8'hA0, v);
    chk("R5 chain zero after reset", v, FC);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule